// File: doc/BRIEF.md
# Flash Prefetch Accelerator Controller

This block sits between a processor bus and a slow on-chip flash array. It keeps recently fetched flash lines in three holding latches: one for the current instruction line, one for the next sequential instruction line (filled by prefetch), and one for data. A two-bit policy input picks how much the latches are trusted. In the off policy every access costs a full flash read time. In the partial policy only sequential instruction fetches may be served from a latch. In the full policy any access that hits its latch is served from it.

The flash read time is set by a three-bit fetch-timing input. A request is held on the CPU side until a one-cycle ready strobe returns the selected 32-bit word. On the flash side the block issues one-cycle line requests with a line address and takes the 128-bit line when valid is returned. A single-cycle invalidate input, raised when a flash program or erase operation starts, discards everything latched so that no stale value can be returned.

Top module: `flash_accel`

## Requirements
- R1: `mode` selects the policy: 0 = off, 1 = partial, 2 = full; the code 3 behaves exactly as 2.
- R2: With N = `fetch_cycles` (a value of 0 counts as 1), an access that starts a flash read, or that is served from a latch in mode 0, raises `cpu_ready` N clock edges after the edge at which it is accepted. An access served from a latch in mode 1 or 2 raises it after 1 edge. `cpu_ready` is high for exactly one cycle. `cpu_ready` stays low for the whole count of an active read. `cpu_ready` and `fl_req` are low after reset.
- R3: In mode 0 no prefetch is issued. A latch hit returns the latched word after the full N-edge time and issues no flash request. A miss issues exactly one flash request.
- R4: In mode 1 a sequential instruction access (`cpu_instr`=1, `cpu_seq`=1) whose line is held in the instruction or prefetch latch is served from it, with no flash request.
- R5: In mode 1 a non-sequential instruction access always issues a flash read, even when its line is latched.
- R6: In mode 1 every data access (`cpu_instr`=0) issues a flash read, whatever the latches hold.
- R7: In mode 2 any instruction access that hits the instruction or prefetch latch is served from a latch with no flash request. The same holds for a data access that hits the data latch. A miss issues a flash read.
- R8: In modes 1 and 2, every completed instruction access is followed by a prefetch of line address plus one into the prefetch latch, unless that latch already holds that line. A later instruction access to the prefetched line is a latch hit. A hit on the prefetch latch moves that line into the instruction latch and starts the next prefetch.
- R9: A request that arrives while a prefetch is in progress waits for that prefetch to finish before it is evaluated. The prefetched line stays in the prefetch latch when the request is for another line.
- R10: An `invalidate` pulse clears all three latches. The next access to any earlier latched line issues a flash read. A read in progress during the pulse still returns its word, but its line is not kept.
- R11: A line is 4 words of 32 bits. `fl_addr` carries `cpu_addr[15:4]`, and `cpu_rdata` carries word `cpu_addr[3:2]` of the line, where word k occupies line bits [32k+31:32k].
- R12: With `fetch_cycles` = 1, every access completes after 1 edge, whether it hits or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Latch policy: 0 off, 1 partial, 2/3 full |
| fetch_cycles | input | 3 | Flash read time in clocks, 0 treated as 1 |
| invalidate | input | 1 | Pulse at the start of a flash program or erase |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_seq | input | 1 | Access is sequential to the previous one |
| cpu_instr | input | 1 | 1 for instruction fetch, 0 for data read |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Returned word, valid with `cpu_ready` |
| fl_req | output | 1 | One-cycle flash line request |
| fl_addr | output | 12 | Line address of the request |
| fl_rvalid | input | 1 | Flash line return valid |
| fl_rline | input | 128 | Returned flash line |

## Verification
The main sweep goes through every policy, every fetch-timing code including 0 and 1, both access kinds and both sequential flags. Each combination starts from cleared latches with a miss, then reads a second word of the same line, then reads the following line. The miss latency, hit latency and flash request count tell a latch hit apart from a fetch, and the fast path apart from the timed off-mode path. The prefetch behaviour shows up as one extra request after each instruction access. Directed sequences then send a data request into a running prefetch and check that the prefetched line survives. They pulse invalidate both between accesses and in the middle of a read, and run code 3 against full mode.

// File: rtl/flash_accel.sv
module flash_accel #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int WPL = 4,
  parameter int CW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic [CW-1:0]         fetch_cycles,
  input  logic                  invalidate,
  input  logic                  cpu_req,
  input  logic [AW-1:0]         cpu_addr,
  input  logic                  cpu_seq,
  input  logic                  cpu_instr,
  output logic                  cpu_ready,
  output logic [DW-1:0]         cpu_rdata,
  output logic                  fl_req,
  output logic [AW-$clog2(WPL)-$clog2(DW/8)-1:0] fl_addr,
  input  logic                  fl_rvalid,
  input  logic [DW*WPL-1:0]     fl_rline
);
  localparam int BO  = $clog2(DW/8);
  localparam int WIW = $clog2(WPL);
  localparam int OFF = WIW + BO;
  localparam int TW  = AW - OFF;
  localparam int LW  = DW * WPL;

  typedef enum logic [1:0] {S_IDLE, S_DEM, S_PF} st_t;

  st_t           st;
  logic [CW-1:0] cnt, n_eff;
  logic          need, have, stale;
  logic [LW-1:0] lbuf;
  logic          dem_instr;
  logic [1:0]    dem_mode;
  logic [TW-1:0] dem_tag;
  logic [WIW-1:0] dem_wi;
  logic [DW-1:0] hold;

  logic          i_v, p_v, d_v;
  logic [TW-1:0] i_tag, p_tag, d_tag;
  logic [LW-1:0] i_line, p_line, d_line;

  function automatic logic [DW-1:0] pick(input logic [LW-1:0] l, input logic [WIW-1:0] i);
    return l[i*DW +: DW];
  endfunction

  logic [TW-1:0]  a_tag;
  logic [WIW-1:0] a_wi;
  logic           unused_lsb;
  assign a_tag      = cpu_addr[AW-1:OFF];
  assign a_wi       = cpu_addr[OFF-1:BO];
  assign unused_lsb = ^cpu_addr[BO-1:0];

  assign n_eff = (fetch_cycles == '0) ? CW'(1) : fetch_cycles;

  logic hi_i, hi_p, hi_d, hit, use_latch, take;
  assign hi_i = i_v && (i_tag == a_tag);
  assign hi_p = p_v && (p_tag == a_tag);
  assign hi_d = d_v && (d_tag == a_tag);
  assign hit  = (cpu_instr ? (hi_i || hi_p) : hi_d) && !invalidate;
  assign take = (st == S_IDLE) && cpu_req;

  always_comb begin
    case (mode)
      2'd0:    use_latch = hit;
      2'd1:    use_latch = hit && cpu_instr && cpu_seq;
      default: use_latch = hit;
    endcase
  end

  logic [DW-1:0] lat_word;
  assign lat_word = !cpu_instr ? pick(d_line, a_wi) :
                    hi_i       ? pick(i_line, a_wi) : pick(p_line, a_wi);

  logic [LW-1:0] line_now;
  logic          done, pf_go;
  logic [TW-1:0] nxt_tag;
  assign line_now = have ? lbuf : fl_rline;
  assign done     = (st != S_IDLE) && (cnt <= CW'(1)) && (!need || have || fl_rvalid);
  assign nxt_tag  = dem_tag + 1'b1;
  assign pf_go    = dem_instr && (dem_mode != 2'd0) && !(p_v && p_tag == nxt_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      need      <= 1'b0;
      have      <= 1'b0;
      stale     <= 1'b0;
      lbuf      <= '0;
      dem_instr <= 1'b0;
      dem_mode  <= 2'd0;
      dem_tag   <= '0;
      dem_wi    <= '0;
      hold      <= '0;
      i_v       <= 1'b0;
      p_v       <= 1'b0;
      d_v       <= 1'b0;
      i_tag     <= '0;
      p_tag     <= '0;
      d_tag     <= '0;
      i_line    <= '0;
      p_line    <= '0;
      d_line    <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      fl_req    <= 1'b0;
      fl_addr   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      fl_req    <= 1'b0;
      if (fl_rvalid && need && st != S_IDLE) begin
        lbuf <= fl_rline;
        have <= 1'b1;
      end
      case (st)
        S_IDLE: if (take) begin
          dem_instr <= cpu_instr;
          dem_mode  <= mode;
          dem_tag   <= a_tag;
          dem_wi    <= a_wi;
          stale     <= 1'b0;
          have      <= 1'b0;
          st        <= S_DEM;
          if (use_latch) begin
            need <= 1'b0;
            cnt  <= (mode != 2'd0) ? CW'(1) : n_eff;
            hold <= lat_word;
            if (cpu_instr && !hi_i && hi_p) begin
              i_line <= p_line;
              i_tag  <= p_tag;
              i_v    <= 1'b1;
              p_v    <= 1'b0;
            end
          end else begin
            need    <= 1'b1;
            cnt     <= n_eff;
            fl_req  <= 1'b1;
            fl_addr <= a_tag;
          end
        end
        S_DEM: if (done) begin
          cpu_ready <= 1'b1;
          cpu_rdata <= need ? pick(line_now, dem_wi) : hold;
          if (need) begin
            if (dem_instr) begin
              i_line <= line_now;
              i_tag  <= dem_tag;
              i_v    <= !stale;
            end else begin
              d_line <= line_now;
              d_tag  <= dem_tag;
              d_v    <= !stale;
            end
          end
          if (pf_go) begin
            st      <= S_PF;
            fl_req  <= 1'b1;
            fl_addr <= nxt_tag;
            cnt     <= n_eff;
            need    <= 1'b1;
            have    <= 1'b0;
            stale   <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_PF: if (done) begin
          p_line <= line_now;
          p_tag  <= fl_addr;
          p_v    <= !stale;
          st     <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (invalidate) begin
        i_v   <= 1'b0;
        p_v   <= 1'b0;
        d_v   <= 1'b0;
        stale <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_accel_chk.sv
module flash_accel_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [CW-1:0] fetch_cycles,
  input logic          invalidate,
  input logic          cpu_ready,
  input logic          fl_req,
  input logic          take,
  input logic          any_valid
);
  logic          outst;
  logic [7:0]    since;
  logic [1:0]    m_acc;
  logic [CW-1:0] n_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst <= 1'b0;
      since <= '0;
      m_acc <= '0;
      n_acc <= '0;
    end else begin
      if (since != 8'hFF) since <= since + 1'b1;
      if (take) begin
        outst <= 1'b1;
        since <= '0;
        m_acc <= mode;
        n_acc <= (fetch_cycles == '0) ? CW'(1) : fetch_cycles;
      end else if (cpu_ready) begin
        outst <= 1'b0;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (since == 8'(n_acc)) || (m_acc != 2'd0 && since == 8'd1));

  a_r3_off_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && m_acc == 2'd0) |-> since == 8'(n_acc));

  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r2_ready_owed: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> outst);

  a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !cpu_ready && outst && n_acc > CW'(1)) |=> !cpu_ready);

  a_r3_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && cpu_ready) |-> m_acc != 2'd0);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> !any_valid);
endmodule

bind flash_accel flash_accel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .fetch_cycles(fetch_cycles),
  .invalidate(invalidate), .cpu_ready(cpu_ready), .fl_req(fl_req),
  .take(take), .any_valid(i_v | p_v | d_v)
);

// File: tb/sim_flash_accel.sv
`timescale 1ns/1ps
module sim_flash_accel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [2:0]   fetch_cycles = 3'd1;
  logic         invalidate = 1'b0;
  logic         cpu_req = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic         cpu_seq = 1'b0;
  logic         cpu_instr = 1'b0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         fl_req;
  logic [11:0]  fl_addr;
  logic         fl_rvalid;
  logic [127:0] fl_rline;

  int vectors = 0;
  int miscompares = 0;
  int nreq = 0;
  logic [11:0] last_fa = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] fw(input logic [15:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  assign fl_rvalid = fl_req;
  assign fl_rline  = {fw({fl_addr, 4'hC}), fw({fl_addr, 4'h8}),
                      fw({fl_addr, 4'h4}), fw({fl_addr, 4'h0})};

  always @(posedge clk) if (fl_req) begin
    nreq    <= nreq + 1;
    last_fa <= fl_addr;
  end

  flash_accel u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fetch_cycles(fetch_cycles),
    .invalidate(invalidate), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_seq(cpu_seq), .cpu_instr(cpu_instr), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_rvalid(fl_rvalid), .fl_rline(fl_rline)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic [15:0] a, input logic ins, input logic sq,
                        output int lat, output logic [31:0] d);
    int n;
    cpu_addr = a; cpu_instr = ins; cpu_seq = sq; cpu_req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_ready && n < 100);
    cpu_req = 1'b0;
    lat = cpu_ready ? n - 1 : -1;
    d = cpu_rdata;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_inval();
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int lat, r0, ne;
    logic [31:0] d;
    logic [15:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "ready after reset", cpu_ready, 0);
    chk("R2", "flash request after reset", fl_req, 0);

    for (int m = 0; m < 3; m++)
      for (int ft = 0; ft < 8; ft++)
        for (int ins = 0; ins < 2; ins++)
          for (int sq = 0; sq < 2; sq++) begin
            bit use_l, fast, pf;
            string t2;
            ne = (ft == 0) ? 1 : ft;
            mode = 2'(m);
            fetch_cycles = 3'(ft);
            pulse_inval();
            settle();
            x = 16'h0400 + 16'((((m * 8 + ft) * 2 + ins) * 2 + sq) * 64);
            pf = (ins == 1) && (m != 0);
            r0 = nreq;
            do_acc(x, 1'(ins), 1'b0, lat, d);
            chk(ft == 1 ? "R12" : "R2", "miss latency", lat, ne);
            chk("R11", "miss word", d, fw(x));
            chk("R11", "flash line address", last_fa, x >> 4);
            settle();
            chk(pf ? "R8" : "R3", "reads after miss", nreq - r0, pf ? 2 : 1);

            use_l = (m != 1) || (ins == 1 && sq == 1);
            fast  = use_l && (m != 0);
            t2 = (m == 0) ? "R3" : (m == 2) ? "R7" : (ins == 0) ? "R6" : (sq == 1) ? "R4" : "R5";
            r0 = nreq;
            do_acc(x + 16'd4, 1'(ins), 1'(sq), lat, d);
            chk(t2, "same-line latency", lat, fast ? 1 : ne);
            chk("R11", "same-line word", d, fw(x + 16'd4));
            settle();
            chk(t2, "same-line reads", nreq - r0, use_l ? 0 : 1);

            if (pf) begin
              r0 = nreq;
              do_acc(x + 16'd24, 1'b1, 1'b1, lat, d);
              chk("R8", "prefetched line latency", lat, 1);
              chk("R8", "prefetched word", d, fw(x + 16'd24));
              settle();
              chk("R8", "next prefetch issued", nreq - r0, 1);
            end
          end

    mode = 2'd2; fetch_cycles = 3'd5;
    pulse_inval(); settle();
    do_acc(16'h3000, 1'b1, 1'b0, lat, d);
    chk("R9", "instr miss latency", lat, 5);
    r0 = nreq;
    do_acc(16'h5008, 1'b0, 1'b0, lat, d);
    chk("R9", "data wait behind prefetch", lat, 10);
    chk("R9", "data word", d, fw(16'h5008));
    settle();
    chk("R9", "reads for data", nreq - r0, 2);
    r0 = nreq;
    do_acc(16'h3014, 1'b1, 1'b1, lat, d);
    chk("R9", "kept prefetch latency", lat, 1);
    chk("R9", "kept prefetch word", d, fw(16'h3014));

    settle();
    mode = 2'd2; fetch_cycles = 3'd3;
    do_acc(16'h6000, 1'b0, 1'b0, lat, d);
    chk("R7", "data miss", lat, 3);
    do_acc(16'h600C, 1'b0, 1'b1, lat, d);
    chk("R7", "data hit", lat, 1);
    chk("R11", "data hit word 3", d, fw(16'h600C));
    pulse_inval();
    r0 = nreq;
    do_acc(16'h6004, 1'b0, 1'b0, lat, d);
    chk("R10", "after invalidate latency", lat, 3);
    chk("R10", "after invalidate word", d, fw(16'h6004));
    chk("R10", "after invalidate reads", nreq - r0, 1);

    settle();
    fetch_cycles = 3'd7;
    pulse_inval(); settle();
    fork
      do_acc(16'h7008, 1'b0, 1'b0, lat, d);
      begin
        repeat (3) @(negedge clk);
        pulse_inval();
      end
    join
    chk("R10", "read across invalidate latency", lat, 7);
    chk("R10", "read across invalidate word", d, fw(16'h7008));
    settle();
    r0 = nreq;
    do_acc(16'h7000, 1'b0, 1'b0, lat, d);
    chk("R10", "line not kept latency", lat, 7);
    chk("R10", "line not kept reads", nreq - r0, 1);

    settle();
    mode = 2'd3; fetch_cycles = 3'd4;
    pulse_inval(); settle();
    do_acc(16'h8000, 1'b0, 1'b0, lat, d);
    chk("R1", "code 3 miss", lat, 4);
    r0 = nreq;
    do_acc(16'h8008, 1'b0, 1'b0, lat, d);
    chk("R1", "code 3 data hit", lat, 1);
    chk("R1", "code 3 hit reads", nreq - r0, 0);

    settle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule